// File: doc/BRIEF.md
# Write-Leveling Training Sequencer

This block runs one hardware write-leveling pass for one target module on a DDR3-style memory channel. A single start request latches the target module number, the pass number, the populated chip-select mask and the registered-module flag. The block then works through a fixed list of phases. It asks the mode-register generator to put the target into leveling mode and waits for the DRAM timing to settle. It drives the on-die-termination (ODT) mask and enable, and after the ODT has settled it seeds the byte-lane delays (first pass only). It then holds the PHY training enable for a set window. After the window it has the delay unit capture the trained delays and commit them to the target's write-timing fields. Last, it drops ODT, waits for settling, and returns the module to normal mode registers.

Each exchange with the mode-register generator and with the delay unit is a request that stays high until the neighbour acknowledges it. All memory-clock waits come from one shared down-counter. A one-cycle done pulse marks the end of the pass. The PHY's own delay search happens outside the block.

Top module: `wrlvl_seq`

## Requirements
- R1: After a synchronous active-low reset, done_o, mr_req_o, dly_req_o, phy_odt_en_o and phy_train_en_o are low and phy_odt_mask_o is 0.
- R2: A start_i sampled while idle raises mr_req_o with mr_level_o=1 in the next cycle, with mr_dimm_o and phy_dimm_sel_o equal to the latched target. mr_req_o and mr_level_o hold until mr_ack_i is sampled.
- R3: phy_odt_en_o rises exactly 40 clock edges after the edge that samples mr_ack_i for the leveling-mode request.
- R4: For unbuffered modules (registered_i=0), the 4-bit ODT mask is 4'b0011 when chip selects 0 and 2 are both present. Otherwise it is the single bit (target+2) when the target's odd chip select (2*target+1) is present, and the single bit (target) when it is not.
- R5: For registered modules the ODT mask is the single bit (target).
- R6: Seeds are loaded only on pass 1 (pass2_i=0): dly_req_o with dly_op_o=0 and dly_seed_o = 7'h1A for unbuffered or 7'h40 for registered modules ({gross[1:0], fine[4:0]}). On pass 2 no seed request is issued.
- R7: Exactly 10 edges after phy_odt_en_o rises, the seed request appears (pass 1) or phy_train_en_o rises (pass 2). On pass 1, phy_train_en_o rises in the cycle after the seed acknowledge is sampled.
- R8: phy_train_en_o stays high for exactly 200 contiguous cycles on pass 1 and 32 on pass 2. It is high only while phy_odt_en_o is high and never together with dly_req_o.
- R9: When training ends, the capture request (dly_op_o=1) is issued first. After its acknowledge, the commit request (dly_op_o=2) follows while ODT is still enabled.
- R10: phy_odt_en_o falls in the cycle after the commit acknowledge. Exactly 10 edges later, mr_req_o rises with mr_level_o=0.
- R11: done_o is high for exactly one cycle, the cycle after the edge that samples mr_ack_i for the normal-mode request.
- R12: start_i is ignored while a pass is running. It changes neither the latched target nor the timing, and this includes the cycle in which the final acknowledge is sampled. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run one pass (taken only while idle) |
| dimm_i | input | 1 | Target module number |
| pass2_i | input | 1 | 0 = first pass, 1 = second pass |
| cs_present_i | input | 4 | Populated chip selects, bit 2*m+r = module m rank r |
| registered_i | input | 1 | Target channel uses registered modules |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| mr_req_o | output | 1 | Request to the mode-register generator |
| mr_level_o | output | 1 | 1 = leveling mode, 0 = normal mode |
| mr_dimm_o | output | 1 | Target module for the mode-register generator |
| mr_ack_i | input | 1 | Mode-register generator finished |
| dly_req_o | output | 1 | Request to the delay unit |
| dly_op_o | output | 2 | 0 = load seed, 1 = capture, 2 = commit |
| dly_seed_o | output | 7 | Seed delay {gross, fine} |
| dly_ack_i | input | 1 | Delay unit finished |
| phy_dimm_sel_o | output | 1 | Module selected for training in the PHY |
| phy_odt_mask_o | output | 4 | ODT pins driven during leveling |
| phy_odt_en_o | output | 1 | PHY drives leveling ODT |
| phy_train_en_o | output | 1 | PHY training enable |

## Verification
The final normal-mode acknowledge, which ends a pass and raises done, can coincide with a new start request. The bench holds start_i high, with a different target and pass, through both the acknowledge cycle and the following done cycle. The request in the acknowledge cycle must be ignored: done must still appear with no mode-register request. The request in the done cycle must launch exactly one new pass, whose leveling request names the new target and which then runs to completion with the new pass's window lengths.

// File: rtl/wrlvl_pkg.sv
// Shared types for the write-leveling sequencer.
// Assumes: one FSM owner; the delay-unit op codes are decoded by the neighbour.
package wrlvl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MR_LVL,
        ST_W_MRS,
        ST_W_ODT_ON,
        ST_SEED,
        ST_TRAIN,
        ST_CAPTURE,
        ST_COMMIT,
        ST_W_ODT_OFF,
        ST_MR_NORM
    } seq_state_e;

    typedef enum logic [1:0] {
        DLY_LOAD_SEED = 2'd0,
        DLY_CAPTURE   = 2'd1,
        DLY_COMMIT    = 2'd2
    } dly_op_e;

endpackage

// File: rtl/wrlvl_wait_timer.sv
// Shared down-counter for every wait phase of the sequencer.
// Assumes: load_val_i = wait length - 1; expired_o is high while the count is 0,
// so a phase that loads N-1 on entry lasts exactly N cycles.
module wrlvl_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new wait length or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o)
        else $error("wait timer left zero without a load");

endmodule

// File: rtl/wrlvl_odt_mask.sv
// Computes the leveling ODT pin mask from the latched channel configuration.
// Assumes: NUM_DIMMS >= 2, two chip selects per module (bit 2*m+r).
module wrlvl_odt_mask #(
    parameter int NUM_DIMMS = 2,
    localparam int DIMM_W   = $clog2(NUM_DIMMS),
    localparam int CS_W     = 2 * NUM_DIMMS,
    localparam int CS_IDX_W = DIMM_W + 1
) (
    input  logic [DIMM_W-1:0] dimm_i,
    input  logic [CS_W-1:0]   cs_present_i,
    input  logic              registered_i,
    output logic [CS_W-1:0]   mask_o
);

    logic [CS_IDX_W-1:0] odd_cs_idx;
    logic [CS_IDX_W-1:0] far_idx;

    assign odd_cs_idx = {dimm_i, 1'b1};
    assign far_idx    = CS_IDX_W'(dimm_i) + CS_IDX_W'(NUM_DIMMS);

    // Pick the ODT pins: registered rule, both-first-ranks rule, then rank rule.
    always_comb begin
        mask_o = '0;
        if (registered_i) begin
            mask_o[dimm_i] = 1'b1;
        end else if (cs_present_i[0] && cs_present_i[2]) begin
            mask_o[1:0] = 2'b11;
        end else if (cs_present_i[odd_cs_idx]) begin
            mask_o[far_idx] = 1'b1;
        end else begin
            mask_o[dimm_i] = 1'b1;
        end
    end

endmodule

// File: rtl/wrlvl_seq.sv
// Write-leveling training sequencer: one pass for one target module.
// Order: leveling MR -> settle -> ODT on -> settle -> seed (pass 1) -> train
// window -> capture -> commit -> ODT off -> settle -> normal MR -> done pulse.
// Assumes: neighbours hold their ack for one cycle per request; start_i is
// only looked at while idle.
module wrlvl_seq #(
    parameter int          NUM_DIMMS  = 2,
    parameter int          DLY_W      = 7,
    parameter logic [6:0]  SEED_UNBUF = 7'h1A,
    parameter logic [6:0]  SEED_REG   = 7'h40,
    parameter int          T_MRS      = 40,
    parameter int          T_ODT      = 10,
    parameter int          T_TRAIN_P1 = 200,
    parameter int          T_TRAIN_P2 = 32,
    localparam int DIMM_W = $clog2(NUM_DIMMS),
    localparam int CS_W   = 2 * NUM_DIMMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIMM_W-1:0] dimm_i,
    input  logic              pass2_i,
    input  logic [CS_W-1:0]   cs_present_i,
    input  logic              registered_i,
    output logic              done_o,
    output logic              mr_req_o,
    output logic              mr_level_o,
    output logic [DIMM_W-1:0] mr_dimm_o,
    input  logic              mr_ack_i,
    output logic              dly_req_o,
    output logic [1:0]        dly_op_o,
    output logic [DLY_W-1:0]  dly_seed_o,
    input  logic              dly_ack_i,
    output logic [DIMM_W-1:0] phy_dimm_sel_o,
    output logic [CS_W-1:0]   phy_odt_mask_o,
    output logic              phy_odt_en_o,
    output logic              phy_train_en_o
);
    import wrlvl_pkg::*;

    localparam int T_A   = (T_MRS > T_ODT) ? T_MRS : T_ODT;
    localparam int T_B   = (T_TRAIN_P1 > T_TRAIN_P2) ? T_TRAIN_P1 : T_TRAIN_P2;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W = $clog2(T_MAX + 1);

    seq_state_e        state_q, state_d;
    logic [DIMM_W-1:0] dimm_q;
    logic              pass2_q;
    logic [CS_W-1:0]   cs_q;
    logic              reg_q;
    logic              odt_en_q;
    logic [CS_W-1:0]   odt_mask_q;
    logic              done_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              odt_on;
    logic              odt_off;
    logic              finish;
    logic              accept;
    logic [CS_W-1:0]   odt_mask_calc;

    wrlvl_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    wrlvl_odt_mask #(.NUM_DIMMS(NUM_DIMMS)) u_odt (
        .dimm_i       (dimm_q),
        .cs_present_i (cs_q),
        .registered_i (reg_q),
        .mask_o       (odt_mask_calc)
    );

    assign accept = (state_q == ST_IDLE) && start_i;

    // Phase sequencing: next state, timer loads and ODT set/clear strobes.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        odt_on   = 1'b0;
        odt_off  = 1'b0;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_MR_LVL;
            end
            ST_MR_LVL: begin
                if (mr_ack_i) begin
                    state_d  = ST_W_MRS;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_MRS - 1);
                end
            end
            ST_W_MRS: begin
                if (tmr_expired) begin
                    state_d  = ST_W_ODT_ON;
                    odt_on   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_ODT - 1);
                end
            end
            ST_W_ODT_ON: begin
                if (tmr_expired) begin
                    if (pass2_q) begin
                        state_d  = ST_TRAIN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_TRAIN_P2 - 1);
                    end else begin
                        state_d = ST_SEED;
                    end
                end
            end
            ST_SEED: begin
                if (dly_ack_i) begin
                    state_d  = ST_TRAIN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_TRAIN_P1 - 1);
                end
            end
            ST_TRAIN: begin
                if (tmr_expired) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (dly_ack_i) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (dly_ack_i) begin
                    state_d  = ST_W_ODT_OFF;
                    odt_off  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_ODT - 1);
                end
            end
            ST_W_ODT_OFF: begin
                if (tmr_expired) state_d = ST_MR_NORM;
            end
            ST_MR_NORM: begin
                if (mr_ack_i) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and end-of-pass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
        end
    end

    // Latch the pass configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dimm_q  <= '0;
            pass2_q <= 1'b0;
            cs_q    <= '0;
            reg_q   <= 1'b0;
        end else if (accept) begin
            dimm_q  <= dimm_i;
            pass2_q <= pass2_i;
            cs_q    <= cs_present_i;
            reg_q   <= registered_i;
        end
    end

    // ODT enable and mask: captured when leveling ODT is switched on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odt_en_q   <= 1'b0;
            odt_mask_q <= '0;
        end else if (odt_on) begin
            odt_en_q   <= 1'b1;
            odt_mask_q <= odt_mask_calc;
        end else if (odt_off) begin
            odt_en_q   <= 1'b0;
        end
    end

    // Delay-unit op code decode.
    always_comb begin
        case (state_q)
            ST_CAPTURE: dly_op_o = DLY_CAPTURE;
            ST_COMMIT:  dly_op_o = DLY_COMMIT;
            default:    dly_op_o = DLY_LOAD_SEED;
        endcase
    end

    assign done_o         = done_q;
    assign mr_req_o       = (state_q == ST_MR_LVL) || (state_q == ST_MR_NORM);
    assign mr_level_o     = (state_q == ST_MR_LVL);
    assign mr_dimm_o      = dimm_q;
    assign dly_req_o      = (state_q == ST_SEED) || (state_q == ST_CAPTURE) ||
                            (state_q == ST_COMMIT);
    assign dly_seed_o     = DLY_W'(reg_q ? SEED_REG : SEED_UNBUF);
    assign phy_dimm_sel_o = dimm_q;
    assign phy_odt_mask_o = odt_mask_q;
    assign phy_odt_en_o   = odt_en_q;
    assign phy_train_en_o = (state_q == ST_TRAIN);

    // R2
    mr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_req_o && !mr_ack_i) |=> (mr_req_o && $stable(mr_level_o)))
        else $error("mode-register request dropped before acknowledge");

    // R4
    odt_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_odt_en_o |-> (($countones(phy_odt_mask_o) == 1) ||
                          (phy_odt_mask_o == CS_W'(3))))
        else $error("ODT mask has an illegal shape");

    // R8
    train_odt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_train_en_o |-> (phy_odt_en_o && !dly_req_o))
        else $error("training enable without ODT or during a delay request");

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held longer than one cycle");

    // R12
    busy_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(phy_dimm_sel_o))
        else $error("target changed during a pass");

endmodule

// File: tb/wrlvl_seq_tb.sv
module wrlvl_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       dimm_i = 1'b0;
    logic       pass2_i = 1'b0;
    logic [3:0] cs_present_i = 4'b0;
    logic       registered_i = 1'b0;
    logic       mr_ack_i = 1'b0;
    logic       dly_ack_i = 1'b0;

    logic       done_o, mr_req_o, mr_level_o, mr_dimm_o;
    logic       dly_req_o;
    logic [1:0] dly_op_o;
    logic [6:0] dly_seed_o;
    logic       phy_dimm_sel_o;
    logic [3:0] phy_odt_mask_o;
    logic       phy_odt_en_o, phy_train_en_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wrlvl_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dimm_i(dimm_i),
        .pass2_i(pass2_i), .cs_present_i(cs_present_i), .registered_i(registered_i),
        .done_o(done_o), .mr_req_o(mr_req_o), .mr_level_o(mr_level_o),
        .mr_dimm_o(mr_dimm_o), .mr_ack_i(mr_ack_i), .dly_req_o(dly_req_o),
        .dly_op_o(dly_op_o), .dly_seed_o(dly_seed_o), .dly_ack_i(dly_ack_i),
        .phy_dimm_sel_o(phy_dimm_sel_o), .phy_odt_mask_o(phy_odt_mask_o),
        .phy_odt_en_o(phy_odt_en_o), .phy_train_en_o(phy_train_en_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic d, input logic [3:0] cs, input bit rg);
        if (rg) return 4'(1) << d;
        if (cs[0] && cs[2]) return 4'b0011;
        if (cs[{d, 1'b1}]) return 4'(1) << (int'(d) + 2);
        return 4'(1) << d;
    endfunction

    // Pulse start for one cycle with the given configuration.
    task automatic issue_start(input logic d, input logic p2, input logic [3:0] cs, input bit rg);
        @(negedge clk);
        start_i = 1'b1; dimm_i = d; pass2_i = p2; cs_present_i = cs; registered_i = rg;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Drive one pass from the cycle after its start edge to done and check every phase.
    task automatic run_body(input logic d, input logic p2, input logic [3:0] cs, input bit rg,
                            input bit poke, input bit b2b, input logic nd, input logic np2,
                            input logic [3:0] ncs, input bit nrg);
        int n;
        bit saw;
        check("R2", "mr_req after start", int'(mr_req_o), 1);
        check("R2", "mr_level leveling", int'(mr_level_o), 1);
        check("R2", "mr_dimm", int'(mr_dimm_o), int'(d));
        check("R2", "phy_dimm_sel", int'(phy_dimm_sel_o), int'(d));
        @(negedge clk); @(negedge clk);
        check("R2", "mr_req held until ack", int'(mr_req_o && mr_level_o), 1);
        mr_ack_i = 1'b1; @(negedge clk); mr_ack_i = 1'b0;
        n = 0;
        while (!phy_odt_en_o && n < 1000) begin
            if (poke && n == 5) begin start_i = 1'b1; dimm_i = ~d; end
            else begin start_i = 1'b0; dimm_i = d; end
            @(negedge clk); n++;
        end
        start_i = 1'b0; dimm_i = d;
        check("R3", "edges from MR ack to ODT enable", n, 40);
        if (poke) begin
            check("R12", "target kept after busy start", int'(phy_dimm_sel_o), int'(d));
            check("R12", "mr_dimm kept after busy start", int'(mr_dimm_o), int'(d));
        end
        check(rg ? "R5" : "R4", "ODT mask", int'(phy_odt_mask_o), int'(exp_mask(d, cs, rg)));
        n = 0; saw = 1'b0;
        while (!(p2 ? phy_train_en_o : dly_req_o) && n < 1000) begin
            if (dly_req_o) saw = 1'b1;
            @(negedge clk); n++;
        end
        check("R7", "edges from ODT enable to seed or train", n, 10);
        if (p2) begin
            check("R6", "no seed request on pass 2", int'(saw || dly_req_o), 0);
        end else begin
            check("R6", "seed op code", int'(dly_op_o), 0);
            check("R6", "seed value", int'(dly_seed_o), rg ? 'h40 : 'h1A);
            check("R7", "no training before seed ack", int'(phy_train_en_o), 0);
            dly_ack_i = 1'b1; @(negedge clk); dly_ack_i = 1'b0;
            check("R7", "train after seed ack", int'(phy_train_en_o), 1);
        end
        n = 0;
        while (phy_train_en_o && n < 1000) begin
            @(negedge clk); n++;
        end
        check("R8", "training window length", n, p2 ? 32 : 200);
        check("R9", "capture request", int'(dly_req_o), 1);
        check("R9", "capture op code", int'(dly_op_o), 1);
        dly_ack_i = 1'b1; @(negedge clk); dly_ack_i = 1'b0;
        check("R9", "commit op code", int'(dly_req_o ? dly_op_o : 2'd3), 2);
        check("R9", "ODT still on at commit", int'(phy_odt_en_o), 1);
        dly_ack_i = 1'b1; @(negedge clk); dly_ack_i = 1'b0;
        check("R10", "ODT off after commit ack", int'(phy_odt_en_o), 0);
        n = 0;
        while (!mr_req_o && n < 1000) begin
            @(negedge clk); n++;
        end
        check("R10", "edges from ODT off to restore request", n, 10);
        check("R10", "restore is normal mode", int'(mr_level_o), 0);
        if (b2b) begin
            start_i = 1'b1; dimm_i = nd; pass2_i = np2; cs_present_i = ncs; registered_i = nrg;
        end
        check("R11", "no done before restore ack", int'(done_o), 0);
        mr_ack_i = 1'b1; @(negedge clk); mr_ack_i = 1'b0;
        check("R11", "done after restore ack", int'(done_o), 1);
        check("R12", "start in ack cycle ignored", int'(mr_req_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        check("R11", "done is one cycle", int'(done_o), 0);
        if (b2b) begin
            check("R12", "start in done cycle accepted", int'(mr_req_o && mr_level_o), 1);
        end
    endtask

    task automatic test_reset();
        check("R1", "done", int'(done_o), 0);
        check("R1", "mr_req", int'(mr_req_o), 0);
        check("R1", "dly_req", int'(dly_req_o), 0);
        check("R1", "odt_en", int'(phy_odt_en_o), 0);
        check("R1", "train_en", int'(phy_train_en_o), 0);
        check("R1", "odt mask", int'(phy_odt_mask_o), 0);
    endtask

    task automatic test_pass(input logic d, input logic p2, input logic [3:0] cs, input bit rg,
                             input bit poke);
        issue_start(d, p2, cs, rg);
        run_body(d, p2, cs, rg, poke, 1'b0, 1'b0, 1'b0, 4'b0, 1'b0);
    endtask

    task automatic test_back_to_back();
        issue_start(1'b0, 1'b1, 4'b0011, 1'b0);
        run_body(1'b0, 1'b1, 4'b0011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0101, 1'b0);
        run_body(1'b1, 1'b0, 4'b0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0, 1'b0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_pass(1'b0, 1'b0, 4'b0101, 1'b0, 1'b0);
        test_pass(1'b1, 1'b1, 4'b1010, 1'b0, 1'b0);
        test_pass(1'b0, 1'b0, 4'b0001, 1'b0, 1'b0);
        test_pass(1'b1, 1'b0, 4'b1111, 1'b1, 1'b0);
        test_pass(1'b1, 1'b1, 4'b0100, 1'b0, 1'b1);
        test_back_to_back();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule